// File: doc/BRIEF.md
# Bidirectional GPIO Pin Bank

This block controls a bank of eight bidirectional pins through a small register bus. Three registers sit behind that bus. A direction register chooses input or output for each pin. A level register has two jobs: it sets the driven level of an output pin, and it switches the weak pull-up of an input pin on or off. A read-only sample register returns the levels seen on the pins. Bit n of every register belongs to pin n.

The pad interface has three outputs per pin: a level, a drive enable and a pull-up enable. The raw pin levels come back through a two-stage synchronizer. Each pin also has an alternate-function enable. When it is set, a peripheral supplies the pin's level and drive enable in place of the registers. At no time are the pull-up and the driver on together. After reset every pin is an undriven input. Pin 3 is the one exception: it comes up with its pull-up enabled.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register (offset 0) reads 0x00, the level register (offset 1) reads 0x08, pad_oe is 0x00 and pad_pu is 0x08, so pin 3 is the only pin pulled up.
- R2: A write with bus_addr = 0 loads the direction register on that clock edge, and reads at offset 0 return the value written.
- R3: A write with bus_addr = 1 loads the level register on that clock edge, and reads at offset 1 return the value written.
- R4: For a pin whose direction bit is 1 and whose alternate enable is 0, pad_oe is 1 and pad_out equals the pin's level bit (1 high, 0 low).
- R5: For a pin whose direction bit is 0 and whose alternate enable is 0, pad_oe is 0 and pad_pu equals the pin's level bit. For an output pin pad_pu is 0.
- R6: A read at offset 2 returns pin_in as sampled through two flops, whatever the pin directions. A change on pin_in becomes visible on the second rising edge after it and is not yet visible after the first.
- R7: Writes at offsets 2 and 3 change no register, and reads at offset 3 return 0.
- R8: When alt_en[n] is 1, pad_oe[n] = alt_oe[n] and pad_out[n] = alt_out[n]. pad_pu[n] is 0 whenever pad_oe[n] is 1.

Top module port order matches the table below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register offset: 0 direction, 1 level, 2 pin sample |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Raw levels from the pads |
| alt_en | input | 8 | Per-pin alternate-function select |
| alt_out | input | 8 | Alternate-function output level |
| alt_oe | input | 8 | Alternate-function drive enable |
| pad_out | output | 8 | Level to the pad driver |
| pad_oe | output | 8 | Pad driver enable |
| pad_pu | output | 8 | Weak pull-up enable |

## Verification
Two functions can act on the same pin in the same cycle: register control and alternate-function override. The bench sets up this collision by writing levels of 1 to every pin configured as an input, so each pin would be pulled up, and then asserting alt_en on some of those pins with alt_oe high on a subset. On the overridden pins it expects the alternate level and drive enable. It expects the pull-up to be dropped only on pins that are actually driven. Register-controlled pins next to them must keep their own behaviour. The second collision is between a pin driven as an output and a sample read: the bench checks that the synchronized value of such a pin still reaches offset 2.

// File: rtl/gpio_bank_pkg.sv
// Package: shared address width and register offsets of the pin bank.
package gpio_bank_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DIR  = 2'd0,
        OFF_LVL  = 2'd1,
        OFF_SMP  = 2'd2,
        OFF_NONE = 2'd3
    } reg_off_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Purpose: a synchronizer chain of STAGES flops for each pin.
// Assumes: the pin levels are asynchronous to clk, and each pin is
// sampled on its own (no bus coherency across pins).
module gpio_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] synced
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][NPINS-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pin levels one stage down the chain on each edge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[s] <= '0;
            else if (s == 0)
                stg[s] <= raw;
            else
                stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    assign synced = stg[LAST];
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Purpose: holds the direction and level registers and decodes writes
// and reads. Offset 2 returns the synchronized pin sample; offset 3
// reads as zero. Writes at offsets 2 and 3 are dropped.
// Assumes: single-cycle write strobe, combinational read path.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int               NPINS   = 8,
    parameter logic [NPINS-1:0] LVL_RST = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  sample,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  lvl_q,
    output logic [NPINS-1:0]  rdata
);
    reg_off_e off;
    assign off = reg_off_e'(addr);

    // Direction register: cleared on reset, loaded on a write at offset 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr && off == OFF_DIR)
            dir_q <= wdata;
    end

    // Level register: reset to LVL_RST, loaded on a write at offset 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= LVL_RST;
        else if (wr && off == OFF_LVL)
            lvl_q <= wdata;
    end

    // Read mux for the current offset.
    always_comb begin
        unique case (off)
            OFF_DIR: rdata = dir_q;
            OFF_LVL: rdata = lvl_q;
            OFF_SMP: rdata = sample;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_padmux.sv
// Module: gpio_padmux
// Purpose: turns each pin's direction/level pair, or its alternate
// function, into the three pad controls.
// Assumes: the pull-up must never be on while the pin is driven.
module gpio_padmux #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] lvl_q,
    input  logic [NPINS-1:0] alt_en,
    input  logic [NPINS-1:0] alt_out,
    input  logic [NPINS-1:0] alt_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Pad controls for one pin.
        always_comb begin
            if (alt_en[i]) begin
                pad_oe[i]  = alt_oe[i];
                pad_out[i] = alt_out[i];
            end else begin
                pad_oe[i]  = dir_q[i];
                pad_out[i] = lvl_q[i];
            end
            pad_pu[i] = lvl_q[i] & ~dir_q[i] & ~pad_oe[i];
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: gpio_bank (top)
// Purpose: a bank of NPINS bidirectional pins with a direction register,
// a dual-role level register and a synchronized sample register.
// Assumes: synchronous active-low reset; the pads resolve the
// out/oe/pu controls.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int               NPINS     = 8,
    parameter int               SYNC_STGS = 2,
    parameter logic [NPINS-1:0] LVL_RST   = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  alt_en,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu
);
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] lvl_q;
    logic [NPINS-1:0] smp_q;

    gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STGS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (smp_q)
    );

    gpio_regs #(.NPINS(NPINS), .LVL_RST(LVL_RST)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .sample (smp_q),
        .dir_q  (dir_q),
        .lvl_q  (lvl_q),
        .rdata  (bus_rdata)
    );

    gpio_padmux #(.NPINS(NPINS)) u_pad (
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .alt_en  (alt_en),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
// Module: gpio_bank_chk
// Purpose: temporal checks on the pin bank, attached by bind.
// Assumes: a two-stage synchronizer, as set by the default parameter.
module gpio_bank_chk #(
    parameter int               NPINS   = 8,
    parameter logic [NPINS-1:0] LVL_RST = 8'h08
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] lvl_q,
    input logic [NPINS-1:0] smp_q,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pu
);
    logic [1:0] age;

    // Count the cycles since reset, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (age != 2'd2)
            age <= age + 2'd1;
    end

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> (dir_q == '0 && lvl_q == LVL_RST));

    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> dir_q == $past(bus_wdata));

    p_lvl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> lvl_q == $past(bus_wdata));

    p_sync_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> smp_q == $past(pin_in, 2));

    p_ignore_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1]) |=> ($stable(dir_q) && $stable(lvl_q)));

    p_no_pu_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .LVL_RST(LVL_RST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_in    (pin_in),
    .dir_q     (dir_q),
    .lvl_q     (lvl_q),
    .smp_q     (smp_q),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] alt_en = '0;
    logic [7:0] alt_out = '0;
    logic [7:0] alt_oe = '0;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // Direction/level pairs: {dir, lvl}
    localparam logic [15:0] VEC [6] = '{
        {8'hFF, 8'h00}, {8'hFF, 8'hFF}, {8'h00, 8'hFF},
        {8'h00, 8'h00}, {8'hA5, 8'h3C}, {8'h0F, 8'h96}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state, observed while reset is still held
        bus_read(2'd0, rd); check("R1 dir", rd, 8'h00);
        bus_read(2'd1, rd); check("R1 lvl", rd, 8'h08);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h08);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R3, R4, R5
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d, l;
            d = VEC[k][15:8]; l = VEC[k][7:0];
            bus_write(2'd0, d);
            bus_write(2'd1, l);
            bus_read(2'd0, rd); check("R2 dir readback", rd, d);
            bus_read(2'd1, rd); check("R3 lvl readback", rd, l);
            check("R4 oe", pad_oe, d);
            check("R4 out", pad_out & d, l & d);
            check("R5 pu", pad_pu, l & ~d);
        end

        // R6: two-flop latency, also on driven pins
        bus_write(2'd0, 8'hF0);
        bus_addr = 2'd2;
        @(negedge clk); pin_in = 8'h5A;
        @(negedge clk); bus_read(2'd2, rd); check("R6 one edge", rd, 8'h00);
        @(negedge clk); bus_read(2'd2, rd); check("R6 two edges", rd, 8'h5A);
        pin_in = 8'hC3;
        @(negedge clk); @(negedge clk);
        bus_read(2'd2, rd); check("R6 any dir", rd, 8'hC3);

        // R7: ignored writes, zero offset 3
        bus_write(2'd0, 8'h12);
        bus_write(2'd1, 8'h34);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd0, rd); check("R7 dir kept", rd, 8'h12);
        bus_read(2'd1, rd); check("R7 lvl kept", rd, 8'h34);
        bus_read(2'd2, rd); check("R7 smp kept", rd, 8'hC3);
        bus_read(2'd3, rd); check("R7 off3 zero", rd, 8'h00);

        // R8: alternate override collides with pulled-up inputs
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'hFF);
        alt_en = 8'h0F; alt_oe = 8'h05; alt_out = 8'h03;
        #1;
        check("R8 oe", pad_oe, 8'h05);
        check("R8 out", pad_out & 8'h0F, 8'h03);
        check("R8 pu", pad_pu, 8'hFA);
        alt_en = 8'h00;
        #1;
        check("R8 release", pad_pu, 8'hFF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule